// File: doc/BRIEF.md
# Latched Alarm Flag Interrupt Controller

This block holds the sticky alarm and warning flags of a pluggable-module management interface, the mask bits that go with them, and a summary interrupt. Monitoring logic drives one raw condition bit per flag. A condition that is present in any cycle sets its flag, and the flag stays set after the condition goes away. The flag clears only when the host reads the byte that holds it.

The host reaches the registers through a plain byte-addressed port. The port has an address, a write strobe with write data, a read strobe, and combinational read data. Eight flag bytes share the interrupt. Each flag byte has a mask byte, and a set mask bit keeps a condition that persists from raising the interrupt again and again. The summary interrupt drives an output pin, and the host can also read it as a status bit. The register port is control and status only and carries no stream, so it has no valid/ready handshake. Read data is valid in the same cycle that the address is presented.

Top module: `alarm_flag_irq_ctrl`

## Requirements
- R1: Condition input bit 8*k+b sets bit b of flag byte at address 80+k on the clock edge where that bit is high, and the flag bit stays 1 after the condition drops.
- R2: A read strobe to flag byte 80+k returns the flag value held before the clear on reg_rdata, and the whole byte reads 0 from the following cycle on if no condition bit of that byte is high.
- R3: A read of one flag byte leaves the flags of every other byte unchanged.
- R4: If a condition bit is high in the same cycle that its byte is read, that flag bit stays 1. Setting takes priority over clear-on-read.
- R5: Mask byte 88+k covers flag byte 80+k bit for bit. The host can write and read it back, and every mask bit is 0 after reset.
- R6: irq_o is 1 exactly when some flag bit is 1 while its mask bit is 0. A read of address 110 returns irq_o in bit 0 and 0 in bits 7..1.
- R7: Bit 0 of mask byte 93 masks the vendor-specific alarm, which is bit 0 of flag byte 85.
- R8: Host writes to flag bytes 80..87 and to address 110 change no register.
- R9: A read of an address outside 80..95 and 110 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | 64 | Raw condition bits, bit 8*k+b maps to flag byte 80+k bit b |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe, triggers clear-on-read of a flag byte |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench sets every one of the 64 flag bits alone and checks that it latches, that the interrupt rises, and that a read returns exactly that bit and then clears it. A design with a wrong byte or bit mapping, or with clearing that happens before the data is returned, fails this sweep. Further cases hold a condition high across its own read, which a clear-first design would drop, and read one byte while another is pending, which catches a clear that spans the whole field. They also check each mask byte against its own flag byte, the vendor mask at byte 93, and writes to the flag and status addresses, which a design that decodes them would let through.

// File: rtl/flag_irq_pkg.sv
package flag_irq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] reg_byte_t;
endpackage

// File: rtl/flag_byte_latch.sv
module flag_byte_latch
  import flag_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_byte_t cond,
  input  logic      rd_hit,
  output reg_byte_t flags
);
  reg_byte_t kept;

  always_comb kept = rd_hit ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | cond;
  end

  // R1
  cond_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond != '0) |=> ((flags & $past(cond)) == $past(cond)));
  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((flags & $past(flags)) == $past(flags)));
  // R2
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && cond == '0) |=> (flags == '0));
endmodule

// File: rtl/mask_byte_reg.sv
module mask_byte_reg
  import flag_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  reg_byte_t wdata,
  output reg_byte_t mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask <= '0;
    else if (wr_hit) mask <= wdata;
  end

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mask == $past(wdata)));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mask));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] flag_vec,
  input  logic [WIDTH-1:0] mask_vec,
  output logic             irq
);
  assign irq = |(flag_vec & ~mask_vec);

  // R6
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vec == '0) |-> !irq);
  // R6
  all_masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '1) |-> !irq);
endmodule

// File: rtl/alarm_flag_irq_ctrl.sv
module alarm_flag_irq_ctrl
  import flag_irq_pkg::*;
#(
  parameter int NBYTES    = 8,
  parameter int ADDR_W    = 8,
  parameter int FLAG_BASE = 80,
  parameter int MASK_BASE = 88,
  parameter int STAT_ADDR = 110
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES*BYTE_W-1:0] cond_in,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic [BYTE_W-1:0]        reg_wdata,
  input  logic                     reg_rd,
  output logic [BYTE_W-1:0]        reg_rdata,
  output logic                     irq_o
);
  localparam int VEC_W = NBYTES * BYTE_W;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [VEC_W-1:0] flag_vec;
  logic [VEC_W-1:0] mask_vec;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    localparam logic [ADDR_W-1:0] F_A = ADDR_W'(FLAG_BASE + k);
    localparam logic [ADDR_W-1:0] M_A = ADDR_W'(MASK_BASE + k);
    reg_byte_t f_q, m_q;

    flag_byte_latch u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (cond_in[k*BYTE_W +: BYTE_W]),
      .rd_hit (reg_rd && reg_addr == F_A),
      .flags  (f_q)
    );

    mask_byte_reg u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (reg_wr && reg_addr == M_A),
      .wdata  (reg_wdata),
      .mask   (m_q)
    );

    assign flag_vec[k*BYTE_W +: BYTE_W] = f_q;
    assign mask_vec[k*BYTE_W +: BYTE_W] = m_q;
  end

  irq_summary #(.WIDTH(VEC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_vec (flag_vec),
    .mask_vec (mask_vec),
    .irq      (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (reg_addr == ADDR_W'(FLAG_BASE + k)) reg_rdata = flag_vec[k*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(MASK_BASE + k)) reg_rdata = mask_vec[k*BYTE_W +: BYTE_W];
    end
    if (reg_addr == STAT_A) reg_rdata = {{(BYTE_W-1){1'b0}}, irq_o};
  end

  // R8
  flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && cond_in == '0) |=> $stable(flag_vec));
  // R3
  read_keeps_other_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && cond_in == '0) |=> ($countones(flag_vec) <= $countones($past(flag_vec))));
endmodule

// File: tb/tb_alarm_flag_irq_ctrl.sv
module tb_alarm_flag_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] cond_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 0;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alarm_flag_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic pulse(input logic [63:0] v);
    @(negedge clk); cond_in = v;
    @(negedge clk); cond_in = '0;
  endtask

  task automatic irq_now(input string req, input logic exp);
    @(negedge clk); #2 chk(req, {7'b0, irq_o}, {7'b0, exp});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // Reset state: flags, masks, status all zero (R5, R6)
    for (int k = 0; k < 16; k++) begin
      rd(8'(80 + k), d);
      chk(k < 8 ? "R2 reset flag" : "R5 reset mask", d, 8'h00);
    end
    rd(8'd110, d); chk("R6 reset status", d, 8'h00);
    irq_now("R6 reset irq", 1'b0);

    // Sweep every flag bit: R1 latch, R6 irq, R2 read-then-clear
    for (int i = 0; i < 64; i++) begin
      pulse(64'(1) << i);
      irq_now("R1/R6 irq after single flag", 1'b1);
      rd(8'(80 + i / 8), d);
      chk("R1 latched bit", d, 8'(1 << (i % 8)));
      rd(8'(80 + i / 8), d);
      chk("R2 cleared after read", d, 8'h00);
      irq_now("R6 irq cleared", 1'b0);
    end

    // R3: reading one byte leaves another pending
    pulse(64'h0000_0000_0000_0C03);
    rd(8'd80, d); chk("R3 first byte", d, 8'h03);
    rd(8'd81, d); chk("R3 other byte kept", d, 8'h0C);
    irq_now("R3 irq cleared", 1'b0);

    // R4: condition held during read keeps flag
    @(negedge clk); cond_in = 64'h0000_0000_0010_0000;
    rd(8'd82, d); chk("R4 read while held", d, 8'h10);
    @(negedge clk); cond_in = '0;
    rd(8'd82, d); chk("R4 flag kept", d, 8'h10);
    rd(8'd82, d); chk("R4 cleared later", d, 8'h00);

    // R5/R6: per-byte mask sweep
    for (int k = 0; k < 8; k++) begin
      wr(8'(88 + k), 8'(8'hA5 ^ k));
      rd(8'(88 + k), d); chk("R5 mask readback", d, 8'(8'hA5 ^ k));
      pulse(64'hFF << (8 * k));
      wr(8'(88 + k), 8'hFF);
      irq_now("R6 fully masked", 1'b0);
      rd(8'd110, d); chk("R6 status masked", d, 8'h00);
      wr(8'(88 + k), 8'h7F);
      irq_now("R6 one bit unmasked", 1'b1);
      rd(8'd110, d); chk("R6 status set", d, 8'h01);
      rd(8'(80 + k), d); chk("R1 masked flag still latched", d, 8'hFF);
      wr(8'(88 + k), 8'h00);
    end

    // R7: vendor alarm mask
    wr(8'd93, 8'h01);
    pulse(64'(1) << 40);
    irq_now("R7 vendor alarm masked", 1'b0);
    pulse(64'(1) << 41);
    irq_now("R7 neighbour unmasked", 1'b1);
    rd(8'd85, d); chk("R7 flag byte", d, 8'h03);
    wr(8'd93, 8'h00);

    // R8: writes to flag and status bytes ignored
    for (int k = 0; k < 8; k++) wr(8'(80 + k), 8'hFF);
    wr(8'd110, 8'hFF);
    irq_now("R8 irq after writes", 1'b0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(80 + k), d); chk("R8 flag unchanged", d, 8'h00);
    end
    rd(8'd110, d); chk("R8 status unchanged", d, 8'h00);

    // R9: unmapped reads
    pulse('1);
    foreach (d[j]) begin end
    rd(8'd79, d);  chk("R9 addr 79", d, 8'h00);
    rd(8'd96, d);  chk("R9 addr 96", d, 8'h00);
    rd(8'd111, d); chk("R9 addr 111", d, 8'h00);
    rd(8'd0, d);   chk("R9 addr 0", d, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule